// File: doc/BRIEF.md
# Two-Mode Interrupt Entry Controller

This block sits beside the control unit of a small move-based processor core. It decides whether a pending interrupt request may be taken. When it takes one, it hands the core a single jump opcode to execute in place of the next fetched instruction. It keeps a copy of the program counter as it stood at entry so that the service routine can return to it. It also holds off further interrupts until that return.

A control byte sets two things: whether interrupts are enabled, and how the vector is obtained. In vectored-device mode the controller pulses an acknowledge, and the requesting device answers on the opcode bus with the jump to execute. In fixed-vector mode the controller builds the jump itself, a literal-to-PC move aimed at a fixed service address. A request is considered only at an instruction boundary. It is further gated by the program counter's address region, so that system service code and the user service area cannot be interrupted.

After entry, the first program-counter write is taken to be the injected jump itself. The next program-counter write ends the service and reopens the controller.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset interrupts are disabled and `irq_off` is high. A control write sets enable from `csr_wdata` bit 5 and the mode from bit 4 (0 = device vector, 1 = fixed vector), so 0x20 enables device-vector mode and 0x30 enables fixed-vector mode. `irq_off` is high whenever the enable bit is clear.
- R2: A request is taken only while `pc` lies in 0x1000–0x3FFF or 0x5000–0xFFFF. A request with `pc` in 0x0000–0x0FFF or 0x4000–0x4FFF is not taken.
- R3: A request is taken only at a clock edge where `insn_boundary` is high.
- R4: In device-vector mode `irq_ack` is high for exactly one cycle, in the cycle after the accepting edge.
- R5: In device-vector mode `dev_opcode` is sampled during the acknowledge cycle. It appears on `inj_opcode` with `inj_valid` high for one cycle, in the cycle after the acknowledge.
- R6: In fixed-vector mode `irq_ack` stays low. `inj_valid` is high for one cycle, in the cycle after the accepting edge, with `inj_opcode` = 0x6238. This encodes bit 15 = 0, bit 14 = 1, bits 13:6 = 0x88 (the upper byte of 0x8800) and bits 5:0 = 0o70.
- R7: `pc_copy` holds the value of `pc` at the accepting edge.
- R8: From the accepting edge until the return, `irq_off` is high, and a request held high gives neither `irq_ack` nor `inj_valid`.
- R9: While in service, the first `pc_wr` is the vector jump and leaves `irq_off` high. The second `pc_wr` ends the service, so `irq_off` falls if interrupts are enabled.
- R10: A request at a boundary in the same cycle as the returning `pc_wr` is not taken at that edge. It is taken at the next boundary edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Level interrupt request |
| insn_boundary | input | 1 | High in the cycle before the next instruction fetch |
| csr_wr | input | 1 | Control byte write strobe |
| csr_wdata | input | 8 | Control byte: bit 5 enable, bit 4 mode |
| pc | input | 16 | Current program counter |
| pc_wr | input | 1 | Program counter is being written this cycle |
| dev_opcode | input | 16 | Opcode supplied by the device during acknowledge |
| irq_ack | output | 1 | Interrupt acknowledge pulse (device-vector mode) |
| inj_valid | output | 1 | Injected opcode valid, one cycle |
| inj_opcode | output | 16 | Opcode to execute in place of the next fetch |
| pc_copy | output | 16 | Program counter saved at entry |
| irq_off | output | 1 | Interrupts currently disabled |

## Verification
The return write and a new request can land on the same clock edge. That edge both clears the in-service state and evaluates acceptance. The bench provokes this by raising `pc_wr`, `irq_req` and `insn_boundary` together after the vector jump has been consumed. It judges the result by requiring no acknowledge in the following cycle, with `irq_off` already low. It then requires the acknowledge exactly one boundary edge later. Random runs repeat entries across regions, modes and boundary settings against a bench-side region and acceptance model.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int PC_W       = 16;
    localparam int OP_W       = 16;
    localparam int CSR_W      = 8;
    localparam int CSR_EN_BIT = 5;
    localparam int CSR_MD_BIT = 4;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_ACK  = 1'b1
    } seq_e;

    typedef enum logic {
        VEC_DEVICE = 1'b0,
        VEC_FIXED  = 1'b1
    } vec_mode_e;

    typedef struct packed {
        logic      en;
        vec_mode_e mode;
    } irq_cfg_t;

    // Region permit: the lowest 4K and the 0x4000 4K page are shielded.
    function automatic logic pc_region_ok(input logic [PC_W-1:0] p);
        logic [3:0] page;
        page = p[PC_W-1 -: 4];
        return (page != 4'h0) && (page != 4'h4);
    endfunction

    // Literal move of the target's upper byte into a PC destination.
    function automatic logic [OP_W-1:0] lit_jump(input logic [PC_W-1:0] target,
                                                 input logic [5:0] dest);
        return {1'b0, 1'b1, target[PC_W-1 -: 8], dest};
    endfunction

endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
    import irq_entry_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CSR_W-1:0] wdata,
    output irq_cfg_t         cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.en   <= 1'b0;
            cfg.mode <= VEC_DEVICE;
        end else if (wr) begin
            cfg.en   <= wdata[CSR_EN_BIT];
            cfg.mode <= vec_mode_e'(wdata[CSR_MD_BIT]);
        end
    end
endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
    import irq_entry_pkg::*;
(
    input  logic            req,
    input  logic            boundary,
    input  irq_cfg_t        cfg,
    input  logic [PC_W-1:0] pc,
    input  logic            in_service,
    input  seq_e            state,
    output logic            accept
);
    logic region_ok;

    always_comb begin
        region_ok = pc_region_ok(pc);
        accept    = req && boundary && cfg.en && region_ok
                    && !in_service && (state == SEQ_IDLE);
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter logic [PC_W-1:0] VEC_ADDR  = 16'o104000,
    parameter logic [5:0]      JUMP_DEST = 6'o70
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  vec_mode_e       mode,
    input  logic [PC_W-1:0] pc,
    input  logic [OP_W-1:0] dev_opcode,
    input  logic            pc_wr,
    output seq_e            state,
    output logic            in_service,
    output logic            inj_valid,
    output logic [OP_W-1:0] inj_opcode,
    output logic [PC_W-1:0] pc_copy
);
    localparam logic [OP_W-1:0] FIXED_OP = lit_jump(VEC_ADDR, JUMP_DEST);

    logic vec_seen;
    logic pc_wr_live;

    assign pc_wr_live = pc_wr && in_service && (state == SEQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SEQ_IDLE;
            in_service <= 1'b0;
            vec_seen   <= 1'b0;
            inj_valid  <= 1'b0;
            inj_opcode <= '0;
            pc_copy    <= '0;
        end else begin
            inj_valid <= 1'b0;
            if (accept) begin
                in_service <= 1'b1;
                vec_seen   <= 1'b0;
                pc_copy    <= pc;
                if (mode == VEC_FIXED) begin
                    inj_valid  <= 1'b1;
                    inj_opcode <= FIXED_OP;
                end else begin
                    state <= SEQ_ACK;
                end
            end
            if (state == SEQ_ACK) begin
                inj_valid  <= 1'b1;
                inj_opcode <= dev_opcode;
                state      <= SEQ_IDLE;
            end
            if (pc_wr_live) begin
                if (!vec_seen) vec_seen   <= 1'b1;
                else           in_service <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter logic [PC_W-1:0] VEC_ADDR  = 16'o104000,
    parameter logic [5:0]      JUMP_DEST = 6'o70
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_req,
    input  logic             insn_boundary,
    input  logic             csr_wr,
    input  logic [CSR_W-1:0] csr_wdata,
    input  logic [PC_W-1:0]  pc,
    input  logic             pc_wr,
    input  logic [OP_W-1:0]  dev_opcode,
    output logic             irq_ack,
    output logic             inj_valid,
    output logic [OP_W-1:0]  inj_opcode,
    output logic [PC_W-1:0]  pc_copy,
    output logic             irq_off
);
    irq_cfg_t cfg;
    seq_e     state;
    logic     in_service;
    logic     accept;

    irq_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (csr_wr),
        .wdata (csr_wdata),
        .cfg   (cfg)
    );

    irq_accept_gate u_gate (
        .req        (irq_req),
        .boundary   (insn_boundary),
        .cfg        (cfg),
        .pc         (pc),
        .in_service (in_service),
        .state      (state),
        .accept     (accept)
    );

    irq_entry_seq #(
        .VEC_ADDR  (VEC_ADDR),
        .JUMP_DEST (JUMP_DEST)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .mode       (cfg.mode),
        .pc         (pc),
        .dev_opcode (dev_opcode),
        .pc_wr      (pc_wr),
        .state      (state),
        .in_service (in_service),
        .inj_valid  (inj_valid),
        .inj_opcode (inj_opcode),
        .pc_copy    (pc_copy)
    );

    assign irq_ack = (state == SEQ_ACK);
    assign irq_off = !cfg.en || in_service;
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
    import irq_entry_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            irq_req,
    input logic            insn_boundary,
    input logic [PC_W-1:0] pc,
    input logic [OP_W-1:0] dev_opcode,
    input logic            irq_ack,
    input logic            inj_valid,
    input logic [OP_W-1:0] inj_opcode,
    input logic [PC_W-1:0] pc_copy,
    input logic            in_service
);
    p_entry_permitted_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(in_service) |-> $past(pc_region_ok(pc)));

    p_entry_boundary_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(in_service) |-> $past(insn_boundary && irq_req));

    p_ack_single_r4: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !irq_ack);

    p_dev_opcode_r5: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> (inj_valid && inj_opcode == $past(dev_opcode)));

    p_fixed_opcode_r6: assert property (@(posedge clk) disable iff (rst)
        (inj_valid && !$past(irq_ack)) |-> inj_opcode == 16'h6238);

    p_pc_copy_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(in_service) |-> pc_copy == $past(pc));

    p_no_nest_r8: assert property (@(posedge clk) disable iff (rst)
        (in_service && $past(in_service)) |-> !irq_ack);
endmodule

bind irq_entry_ctrl irq_entry_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .irq_req       (irq_req),
    .insn_boundary (insn_boundary),
    .pc            (pc),
    .dev_opcode    (dev_opcode),
    .irq_ack       (irq_ack),
    .inj_valid     (inj_valid),
    .inj_opcode    (inj_opcode),
    .pc_copy       (pc_copy),
    .in_service    (in_service)
);

// File: tb/irq_entry_ctrl_bench.sv
module irq_entry_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] FIXED_JUMP = 16'h6238;

    logic        clk = 1'b0;
    logic        rst;
    logic        irq_req, insn_boundary, csr_wr, pc_wr;
    logic [7:0]  csr_wdata;
    logic [15:0] pc, dev_opcode;
    logic        irq_ack, inj_valid, irq_off;
    logic [15:0] inj_opcode, pc_copy;

    int n_chk = 0;
    int n_bad = 0;
    bit en_m  = 1'b0;
    bit fix_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_entry_ctrl u_irq_entry_ctrl (
        .clk(clk), .rst(rst), .irq_req(irq_req), .insn_boundary(insn_boundary),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .pc(pc), .pc_wr(pc_wr),
        .dev_opcode(dev_opcode), .irq_ack(irq_ack), .inj_valid(inj_valid),
        .inj_opcode(inj_opcode), .pc_copy(pc_copy), .irq_off(irq_off)
    );

    function automatic bit region_allows(input logic [15:0] p);
        return (p >= 16'h1000) && !((p >= 16'h4000) && (p <= 16'h4FFF));
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_csr(input logic [7:0] v);
        csr_wr = 1'b1; csr_wdata = v;
        step();
        csr_wr = 1'b0;
        en_m  = v[5];
        fix_m = v[4];
    endtask

    // Two PC writes: the vector jump, then the return.
    task automatic finish_service();
        pc_wr = 1'b1; step(); pc_wr = 1'b0;
        chk("R9 vector write keeps off", {15'd0, irq_off}, 16'd1);
        pc_wr = 1'b1; step(); pc_wr = 1'b0;
        chk("R9 return reopens", {15'd0, irq_off}, {15'd0, !en_m});
    endtask

    task automatic attempt(input logic [15:0] p, input bit bnd);
        bit take;
        logic [15:0] dv;
        take = en_m && bnd && region_allows(p);
        irq_req = 1'b1; insn_boundary = bnd; pc = p;
        step();
        irq_req = 1'b0; insn_boundary = 1'b0;
        if (!take) begin
            chk("R2/R3 not taken ack", {15'd0, irq_ack}, 16'd0);
            chk("R2/R3 not taken inj", {15'd0, inj_valid}, 16'd0);
            return;
        end
        chk("R7 pc copy", pc_copy, p);
        chk("R8 off at entry", {15'd0, irq_off}, 16'd1);
        if (fix_m) begin
            chk("R6 no ack", {15'd0, irq_ack}, 16'd0);
            chk("R6 inj valid", {15'd0, inj_valid}, 16'd1);
            chk("R6 fixed opcode", inj_opcode, FIXED_JUMP);
            step();
            chk("R6 inj one cycle", {15'd0, inj_valid}, 16'd0);
        end else begin
            chk("R4 ack", {15'd0, irq_ack}, 16'd1);
            chk("R5 no inj yet", {15'd0, inj_valid}, 16'd0);
            dv = 16'($urandom);
            dev_opcode = dv;
            step();
            chk("R4 ack single", {15'd0, irq_ack}, 16'd0);
            chk("R5 inj valid", {15'd0, inj_valid}, 16'd1);
            chk("R5 device opcode", inj_opcode, dv);
        end
        finish_service();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; irq_req = 0; insn_boundary = 0; csr_wr = 0; csr_wdata = 0;
        pc = 0; pc_wr = 0; dev_opcode = 0;
        step(); step();
        rst = 1'b0;
        step();
        chk("R1 reset off", {15'd0, irq_off}, 16'd1);
        chk("R1 reset ack", {15'd0, irq_ack}, 16'd0);

        // R1: disabled controller ignores a permitted request
        attempt(16'h2000, 1'b1);

        // R1 enable, device mode; R2 region edges
        set_csr(8'h20);
        chk("R1 enabled on", {15'd0, irq_off}, 16'd0);
        attempt(16'h0FFF, 1'b1);
        attempt(16'h4000, 1'b1);
        attempt(16'h4FFF, 1'b1);
        attempt(16'h1000, 1'b1);
        attempt(16'h5000, 1'b1);
        // R3: no boundary
        attempt(16'h8000, 1'b0);

        // R8: held request ignored while in service
        irq_req = 1'b1; insn_boundary = 1'b1; pc = 16'h3000;
        step();
        chk("R4 ack held req", {15'd0, irq_ack}, 16'd1);
        step();
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R8 held req no ack", {15'd0, irq_ack}, 16'd0);
            chk("R8 held req no inj", {15'd0, inj_valid}, 16'd0);
        end
        irq_req = 1'b0; insn_boundary = 1'b0;
        pc_wr = 1'b1; step(); pc_wr = 1'b0;

        // R10: return write and request on the same edge
        pc_wr = 1'b1; irq_req = 1'b1; insn_boundary = 1'b1; pc = 16'h6000;
        step();
        pc_wr = 1'b0;
        chk("R10 same edge no ack", {15'd0, irq_ack}, 16'd0);
        chk("R10 service ended", {15'd0, irq_off}, 16'd0);
        step();
        irq_req = 1'b0; insn_boundary = 1'b0;
        chk("R10 taken next edge", {15'd0, irq_ack}, 16'd1);
        step();
        finish_service();

        // R6 fixed-vector mode
        set_csr(8'h30);
        attempt(16'hFFFF, 1'b1);
        attempt(16'h0400, 1'b1);

        // R1 disable write
        set_csr(8'h10);
        chk("R1 disabled off", {15'd0, irq_off}, 16'd1);

        // Random mix
        for (int k = 0; k < 80; k++) begin
            logic [7:0] cv;
            case ($urandom_range(3))
                0: cv = 8'h20;
                1: cv = 8'h30;
                2: cv = 8'h00;
                default: cv = 8'h10;
            endcase
            set_csr(cv);
            attempt(16'($urandom), 1'($urandom_range(1)));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule